// File: doc/BRIEF.md
# Command-Phase Transfer Length Resolver

This block sits beside the transfer engine of a bus target and runs each time a block-move instruction starts. It checks that the controller is attached to the bus as a target, drives the three bus phase lines straight from the instruction's phase field and loads the programmed transfer count. When the instruction is for the command phase, it waits for the first command byte received. From bits [7:5] of that byte it takes the command group and decides whether the transfer length comes from the command format or from the programmed count.

Groups 0, 1, 2 and 5 always force a fixed command block length. Groups 6 and 7 are the vendor-defined groups. They also force a fixed length unless the vendor-keep input is set, in which case the programmed count stands. Groups 3 and 4 always keep the programmed count. When the programmed count is kept and is zero, the block raises a one-cycle illegal-instruction pulse. The transfer engine reads `effCount` as the number of bytes to request.

Top module: `cdbLengthUnit`

## Requirements
- R1: After reset `effCount` is 0, `phaseEn` is 0, the three phase outputs are 0 and `illegalIrq` is 0.
- R2: An `instrStart` pulse while `asTarget` is 0 is rejected. No output changes, and later `firstByteValid` strobes change nothing until an accepted start.
- R3: An `instrStart` pulse with `asTarget` at 1 sets the outputs on the next cycle. `phaseMsg`, `phaseCd` and `phaseIo` take `phaseField[2]`, `[1]` and `[0]`, `phaseEn` goes to 1 and `effCount` takes `progCount`.
- R4: Command phase is the phase field value 3'b010. For any other phase value, `firstByteValid` strobes leave `effCount` unchanged and raise no interrupt.
- R5: In command phase, on the first `firstByteValid` strobe, a group (`firstByte[7:5]`) of 0 gives `effCount` 6, group 1 or 2 gives 10 and group 5 gives 12. The new value is visible on the cycle after the strobe.
- R6: With `vendorKeep` at 0, group 6 gives `effCount` 6 and group 7 gives 10.
- R7: With `vendorKeep` at 1, groups 6 and 7 leave `effCount` at the programmed count. Groups 3 and 4 leave it at the programmed count for either value of `vendorKeep`.
- R8: When the first command byte keeps the programmed count and that count is 0, `illegalIrq` is high for exactly one cycle, on the cycle after the strobe. In every other case it stays low.
- R9: Only the first `firstByteValid` strobe after an accepted command-phase start is decoded. Later strobes have no effect.
- R10: `effCount` changes only on the cycle after an accepted start or after the decoded first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrStart | input | 1 | One-cycle pulse: a block-move instruction begins |
| asTarget | input | 1 | Controller is attached to the bus as a target |
| phaseField | input | 3 | Instruction phase field {msg, cmd/data, in/out} |
| vendorKeep | input | 1 | Keep the programmed count for vendor groups 6 and 7 |
| progCount | input | 24 | Programmed byte count |
| firstByteValid | input | 1 | Strobe: `firstByte` holds a received command byte |
| firstByte | input | 8 | Received command byte |
| effCount | output | 24 | Byte count that will be requested |
| phaseMsg | output | 1 | Message phase line |
| phaseCd | output | 1 | Command/data phase line |
| phaseIo | output | 1 | In/out phase line |
| phaseEn | output | 1 | Phase lines hold an accepted instruction's phase |
| illegalIrq | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The main sweep runs all eight groups against both settings of `vendorKeep`. It uses programmed counts of zero, one, all ones and a mid value, and varies the low five bits of the byte. This separates forced lengths from kept counts, and a kept zero count from a forced length that only happens to replace a zero. A second strobe with a different group follows each decode, which shows whether later bytes are decoded again. A sweep over every non-command phase value checks phase-line mapping and that the decode stays idle. Rejected starts are placed both with no instruction pending and with an instruction already waiting. This tells apart a start that does nothing from one that only partly loads.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

  localparam int LEN_W = 4;
  localparam logic [2:0] CMD_PHASE = 3'b010;

  typedef struct packed {
    logic loadInstr;
    logic decodeByte;
  } ctrlStrobe_t;

  typedef struct packed {
    logic             rewrite;
    logic [LEN_W-1:0] len;
  } groupDecode_t;

  function automatic groupDecode_t decodeGroup(input logic [7:0] cmdByte,
                                               input logic vendorKeep);
    groupDecode_t d;
    logic [2:0] grp;
    grp = cmdByte[7:5];
    d.rewrite = 1'b0;
    d.len = '0;
    case (grp)
      3'd0: begin d.rewrite = 1'b1;        d.len = 4'd6;  end
      3'd1: begin d.rewrite = 1'b1;        d.len = 4'd10; end
      3'd2: begin d.rewrite = 1'b1;        d.len = 4'd10; end
      3'd5: begin d.rewrite = 1'b1;        d.len = 4'd12; end
      3'd6: begin d.rewrite = !vendorKeep; d.len = 4'd6;  end
      3'd7: begin d.rewrite = !vendorKeep; d.len = 4'd10; end
      default: begin d.rewrite = 1'b0;     d.len = '0;    end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cdbCtrl.sv
module cdbCtrl
  import cdb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrStart,
  input  logic        asTarget,
  input  logic [2:0]  phaseField,
  input  logic        firstByteValid,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_WAIT} ctrlState_t;
  ctrlState_t state, stateNext;

  always_comb begin
    strobe.loadInstr  = instrStart && asTarget;
    strobe.decodeByte = (state == ST_WAIT) && firstByteValid && !instrStart;
  end

  always_comb begin
    stateNext = state;
    if (strobe.loadInstr)
      stateNext = (phaseField == CMD_PHASE) ? ST_WAIT : ST_IDLE;
    else if (strobe.decodeByte)
      stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/cdbPath.sv
module cdbPath
  import cdb_pkg::*;
#(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [2:0]         phaseField,
  input  logic               vendorKeep,
  input  logic [COUNT_W-1:0] progCount,
  input  logic [7:0]         firstByte,
  output logic [COUNT_W-1:0] effCount,
  output logic [2:0]         phaseLines,
  output logic               phaseEn,
  output logic               illegalIrq
);

  groupDecode_t dec;
  logic [COUNT_W-1:0] lenWide;
  logic countIsZero;

  always_comb begin
    dec = decodeGroup(firstByte, vendorKeep);
    lenWide = COUNT_W'(dec.len);
    countIsZero = (effCount == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effCount   <= '0;
      phaseLines <= '0;
      phaseEn    <= 1'b0;
      illegalIrq <= 1'b0;
    end else begin
      illegalIrq <= 1'b0;
      if (strobe.loadInstr) begin
        effCount   <= progCount;
        phaseLines <= phaseField;
        phaseEn    <= 1'b1;
      end else if (strobe.decodeByte) begin
        if (dec.rewrite) effCount <= lenWide;
        else             illegalIrq <= countIsZero;
      end
    end
  end

endmodule

// File: rtl/cdbLengthUnit.sv
module cdbLengthUnit
  import cdb_pkg::*;
#(
  parameter int COUNT_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrStart,
  input  logic               asTarget,
  input  logic [2:0]         phaseField,
  input  logic               vendorKeep,
  input  logic [COUNT_W-1:0] progCount,
  input  logic               firstByteValid,
  input  logic [7:0]         firstByte,
  output logic [COUNT_W-1:0] effCount,
  output logic               phaseMsg,
  output logic               phaseCd,
  output logic               phaseIo,
  output logic               phaseEn,
  output logic               illegalIrq
);

  ctrlStrobe_t strobe;
  logic [2:0]  phaseLines;

  cdbCtrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .instrStart    (instrStart),
    .asTarget      (asTarget),
    .phaseField    (phaseField),
    .firstByteValid(firstByteValid),
    .strobe        (strobe)
  );

  cdbPath #(.COUNT_W(COUNT_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .phaseField (phaseField),
    .vendorKeep (vendorKeep),
    .progCount  (progCount),
    .firstByte  (firstByte),
    .effCount   (effCount),
    .phaseLines (phaseLines),
    .phaseEn    (phaseEn),
    .illegalIrq (illegalIrq)
  );

  assign phaseMsg = phaseLines[2];
  assign phaseCd  = phaseLines[1];
  assign phaseIo  = phaseLines[0];

endmodule

module cdbLengthUnitChk #(
  parameter int COUNT_W = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               instrStart,
  input logic               asTarget,
  input logic [2:0]         phaseField,
  input logic               firstByteValid,
  input logic [COUNT_W-1:0] effCount,
  input logic               phaseMsg,
  input logic               phaseCd,
  input logic               phaseIo,
  input logic               phaseEn,
  input logic               illegalIrq
);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalIrq |=> !illegalIrq);

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalIrq |-> $past(firstByteValid) && !$past(instrStart));

  // R4
  irq_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalIrq |-> ({phaseMsg, phaseCd, phaseIo} == 3'b010) && phaseEn);

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrStart && !asTarget) |=> $stable(effCount) && $stable(phaseEn)
      && $stable({phaseMsg, phaseCd, phaseIo}));

  // R3
  phase_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrStart && asTarget) |=> phaseEn
      && ({phaseMsg, phaseCd, phaseIo} == $past(phaseField)));

  // R10
  count_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!instrStart && !firstByteValid) |=> $stable(effCount));

endmodule

bind cdbLengthUnit cdbLengthUnitChk #(.COUNT_W(COUNT_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .instrStart    (instrStart),
  .asTarget      (asTarget),
  .phaseField    (phaseField),
  .firstByteValid(firstByteValid),
  .effCount      (effCount),
  .phaseMsg      (phaseMsg),
  .phaseCd       (phaseCd),
  .phaseIo       (phaseIo),
  .phaseEn       (phaseEn),
  .illegalIrq    (illegalIrq)
);

// File: tb/sim_cdbLengthUnit.sv
`timescale 1ns/1ps
module sim_cdbLengthUnit;

  localparam int CW = 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          instrStart = 1'b0;
  logic          asTarget = 1'b0;
  logic [2:0]    phaseField = 3'b000;
  logic          vendorKeep = 1'b0;
  logic [CW-1:0] progCount = '0;
  logic          firstByteValid = 1'b0;
  logic [7:0]    firstByte = 8'h00;
  logic [CW-1:0] effCount;
  logic          phaseMsg, phaseCd, phaseIo, phaseEn, illegalIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cdbLengthUnit #(.COUNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .instrStart(instrStart), .asTarget(asTarget),
    .phaseField(phaseField), .vendorKeep(vendorKeep), .progCount(progCount),
    .firstByteValid(firstByteValid), .firstByte(firstByte),
    .effCount(effCount), .phaseMsg(phaseMsg), .phaseCd(phaseCd),
    .phaseIo(phaseIo), .phaseEn(phaseEn), .illegalIrq(illegalIrq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  task automatic startInstr(input logic tgt, input logic [2:0] ph,
                            input logic [CW-1:0] cnt);
    instrStart = 1'b1; asTarget = tgt; phaseField = ph; progCount = cnt;
    tick();
    instrStart = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    firstByteValid = 1'b1; firstByte = b;
    tick();
    firstByteValid = 1'b0;
  endtask

  function automatic longint expCount(input int grp, input bit vk,
                                      input longint prog);
    bit forced;
    forced = (grp <= 2) || (grp == 5) || (grp >= 6 && !vk);
    if (!forced) return prog;
    if (grp == 0 || grp == 6) return 6;
    if (grp == 5) return 12;
    return 10;
  endfunction

  initial begin
    longint counts [4] = '{0, 1, 24'hFFFFFF, 24'h000A5C};
    repeat (3) tick();
    // R1 reset values
    check("R1", "effCount", effCount, 0);
    check("R1", "phaseEn", phaseEn, 0);
    check("R1", "phase", {phaseMsg, phaseCd, phaseIo}, 0);
    check("R1", "illegalIrq", illegalIrq, 0);
    rstN = 1'b1;
    tick();

    // R2 rejected start with nothing pending
    startInstr(1'b0, 3'b010, 24'h000123);
    check("R2", "effCount", effCount, 0);
    check("R2", "phaseEn", phaseEn, 0);
    sendByte(8'h00);
    check("R2", "effCount after byte", effCount, 0);
    check("R2", "illegalIrq after byte", illegalIrq, 0);

    // main sweep: groups x vendorKeep x counts
    for (int vk = 0; vk < 2; vk++) begin
      for (int g = 0; g < 8; g++) begin
        for (int c = 0; c < 4; c++) begin
          longint exp;
          logic [7:0] b;
          b = {g[2:0], 5'(c * 7 + g)};
          vendorKeep = vk[0];
          startInstr(1'b1, 3'b010, counts[c][CW-1:0]);
          // R3 load
          check("R3", "effCount load", effCount, counts[c]);
          check("R3", "phase lines", {phaseMsg, phaseCd, phaseIo}, 3'b010);
          check("R3", "phaseEn", phaseEn, 1);
          sendByte(b);
          exp = expCount(g, vk[0], counts[c]);
          if (g >= 6 && vk == 0) check("R6", "vendor forced len", effCount, exp);
          else if (exp != counts[c] || g <= 2 || g == 5)
            check("R5", "forced len", effCount, exp);
          else check("R7", "kept count", effCount, exp);
          // R8 interrupt only for kept zero count
          check("R8", "illegalIrq pulse", illegalIrq,
                ((g == 3 || g == 4 || (g >= 6 && vk == 1)) && counts[c] == 0) ? 1 : 0);
          sendByte({3'(7 - g), 5'd3});
          // R9 later byte ignored, R8 pulse over
          check("R9", "second byte effCount", effCount, exp);
          check("R8", "illegalIrq cleared", illegalIrq, 0);
          tick();
          check("R10", "effCount idle", effCount, exp);
        end
      end
    end

    // R4 non-command phases
    for (int p = 0; p < 8; p++) begin
      if (p == 2) continue;
      startInstr(1'b1, p[2:0], 24'h0);
      check("R3", "phase lines", {phaseMsg, phaseCd, phaseIo}, p);
      sendByte(8'h00);
      check("R4", "effCount unchanged", effCount, 0);
      check("R4", "no irq", illegalIrq, 0);
      sendByte(8'hA0);
      check("R4", "effCount unchanged 2", effCount, 0);
    end

    // R2 rejected start while a command instruction waits
    vendorKeep = 1'b0;
    startInstr(1'b1, 3'b010, 24'h000055);
    startInstr(1'b0, 3'b101, 24'h000999);
    check("R2", "effCount kept", effCount, 24'h55);
    check("R2", "phase kept", {phaseMsg, phaseCd, phaseIo}, 3'b010);
    sendByte(8'hA1);
    check("R5", "pending decode group5", effCount, 12);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule